// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block sets the horizontal and vertical timing of a raster pixel port. In master mode it counts pixels and lines against programmed limits and drives active-low horizontal and vertical sync. In slave mode it leaves the sync pins undriven, samples them as inputs and restarts its counters on their falling edges. In both modes it compares the counters with a programmed window and drives an active-low strobe that marks the pixels of the active region being captured.

A grayscale mode doubles the horizontal period and sync width, because in that mode the programmed values count pixel pairs. The active width is programmed in blocks: eight pixels per block for color and sixteen for grayscale. A stall input freezes all video-side counting. Software programs the block through a byte-wide register bus, one byte per write.

Top module: `vsync_timing_gen`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `hsync_out`, `vsync_out` and `pix_in_n` are 1 and `sync_oe` is 0. Reset clears every configuration field, which leaves the block in slave mode with color scaling.
- R2: A register write stores `reg_wdata` at byte address `reg_addr`. An even address holds bits 7:0 of a 16-bit field and the odd address above it holds bits 15:8. The fields start at these addresses: horizontal period 0, horizontal sync width 2, horizontal delay 4, horizontal active blocks 6, vertical period 8, vertical sync width 10, vertical delay 12, vertical active lines 14. Address 16 is the mode byte, with bit 0 = master and bit 1 = grayscale. A write to any address from 17 to 31 has no effect.
- R3: In master mode the pixel counter runs from 0 to its limit and then wraps. The line is P+1 pixels long for color and 2*(P+1) pixels long for grayscale, where P is the horizontal period field. Outputs are registered, so each output reflects the counter state of the previous clock.
- R4: In master mode `hsync_out` is 0 for pixel counts 0 through W, where W is the horizontal width field for color and 2*W+1 for grayscale. Otherwise it is 1.
- R5: In master mode the line counter advances when the pixel counter wraps and repeats every V+1 lines, where V is the vertical period field. `vsync_out` is 0 on lines 0 through the vertical width field.
- R6: The horizontal window starts at the pixel count equal to the horizontal delay field. Its length in pixels is the active-blocks field times 8 for color and times 16 for grayscale.
- R7: The vertical window covers lines D through D+N-1, where D is the vertical delay field and N is the vertical active field. `pix_in_n` is 0 only when both windows contain the current counters and `stall` is 0.
- R8: While `stall` is 1, neither counter moves and the next value of `pix_in_n` is 1.
- R9: In slave mode `hsync_out` and `vsync_out` are 1. A falling edge on `hsync_in` clears the pixel counter and advances the line counter. A falling edge on `vsync_in` clears the line counter, and this takes priority over the advance.
- R10: In slave mode, an input falling edge that arrives in a cycle with `stall` at 1 is not acted upon.
- R11: `sync_oe` follows the master bit with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register byte write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| stall | input | 1 | Freezes video-side counting |
| hsync_in | input | 1 | Sampled horizontal sync (slave mode) |
| vsync_in | input | 1 | Sampled vertical sync (slave mode) |
| hsync_out | output | 1 | Driven horizontal sync, active low |
| vsync_out | output | 1 | Driven vertical sync, active low |
| sync_oe | output | 1 | Output enable for the sync pins |
| pix_in_n | output | 1 | Active-region capture strobe, active low |

## Verification
The bench keeps the default 16-bit fields and programs raster sizes of a few dozen pixels by a handful of lines. Every output can then be predicted from modulo and division arithmetic over complete frames, for every cycle. It sweeps color and grayscale against active widths of zero, one and two blocks, and adds periodic stalls. A 300-pixel line exercises the high bytes of the fields. A slave run with an irregular stall pattern lands stalls on input sync edges.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CFG_W   = 16;
  localparam int NFIELD  = 8;

  typedef struct packed {
    logic [CFG_W-1:0] h_period;
    logic [CFG_W-1:0] h_width;
    logic [CFG_W-1:0] h_delay;
    logic [CFG_W-1:0] h_blocks;
    logic [CFG_W-1:0] v_period;
    logic [CFG_W-1:0] v_width;
    logic [CFG_W-1:0] v_delay;
    logic [CFG_W-1:0] v_lines;
    logic             master;
    logic             gray;
  } vtg_cfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output vtg_cfg_t      cfg
);
  localparam int MODE_ADDR = 2 * NFIELD;

  logic [CFG_W-1:0] fld [NFIELD];
  logic [1:0]       mode_q;

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst) begin
        fld[f] <= '0;
      end else if (we && addr == AW'(2 * f)) begin
        fld[f][7:0] <= wdata;
      end else if (we && addr == AW'(2 * f + 1)) begin
        fld[f][15:8] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                              mode_q <= 2'b00;
    else if (we && addr == AW'(MODE_ADDR)) mode_q <= wdata[1:0];
  end

  always_comb begin
    cfg.h_period = fld[0];
    cfg.h_width  = fld[1];
    cfg.h_delay  = fld[2];
    cfg.h_blocks = fld[3];
    cfg.v_period = fld[4];
    cfg.v_width  = fld[5];
    cfg.v_delay  = fld[6];
    cfg.v_lines  = fld[7];
    cfg.master   = mode_q[0];
    cfg.gray     = mode_q[1];
  end
endmodule

// File: rtl/vtg_axis.sv
module vtg_axis #(
  parameter int DW          = 16,
  parameter bit BLOCK_SCALE = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          gray,
  input  logic          step,
  input  logic          restart,
  input  logic [DW-1:0] period,
  input  logic [DW-1:0] width,
  input  logic [DW-1:0] delay,
  input  logic [DW-1:0] active,
  output logic          wrap_o,
  output logic          sync_lo_o,
  output logic          in_win_o
);
  localparam int CW = DW + 5;

  logic [CW-1:0] cnt, last, wlast, alen, wstart, wend;

  always_comb begin
    if (gray) begin
      last  = (CW'(period) << 1) | CW'(1);
      wlast = (CW'(width)  << 1) | CW'(1);
    end else begin
      last  = CW'(period);
      wlast = CW'(width);
    end
    if (BLOCK_SCALE) alen = gray ? (CW'(active) << 4) : (CW'(active) << 3);
    else             alen = CW'(active);
    wstart = CW'(delay);
    wend   = wstart + alen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
    end else if (step) begin
      if (master)          cnt <= (cnt >= last) ? '0 : cnt + CW'(1);
      else if (cnt != '1)  cnt <= cnt + CW'(1);
    end
  end

  assign wrap_o    = master & step & (cnt >= last);
  assign sync_lo_o = (cnt <= wlast);
  assign in_win_o  = (cnt >= wstart) && (cnt < wend);

  assert_restart_clear_R9: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!step && !restart) |=> $stable(cnt));
endmodule

// File: rtl/vsync_timing_gen.sv
module vsync_timing_gen
  import vtg_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          stall,
  input  logic          hsync_in,
  input  logic          vsync_in,
  output logic          hsync_out,
  output logic          vsync_out,
  output logic          sync_oe,
  output logic          pix_in_n
);
  vtg_cfg_t cfg;
  logic h_in_q, v_in_q, h_fall, v_fall;
  logic h_wrap, h_lo, h_win, v_wrap, v_lo, v_win;
  logic step_v;

  vtg_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .cfg(cfg)
  );

  assign h_fall = ~cfg.master & h_in_q & ~hsync_in;
  assign v_fall = ~cfg.master & v_in_q & ~vsync_in;
  assign step_v = ~stall & (cfg.master ? h_wrap : h_fall);

  vtg_axis #(.DW(CFG_W), .BLOCK_SCALE(1'b1)) h_axis_i (
    .clk(clk), .rst(rst), .master(cfg.master), .gray(cfg.gray),
    .step(~stall), .restart(h_fall & ~stall),
    .period(cfg.h_period), .width(cfg.h_width),
    .delay(cfg.h_delay), .active(cfg.h_blocks),
    .wrap_o(h_wrap), .sync_lo_o(h_lo), .in_win_o(h_win)
  );

  vtg_axis #(.DW(CFG_W), .BLOCK_SCALE(1'b0)) v_axis_i (
    .clk(clk), .rst(rst), .master(cfg.master), .gray(1'b0),
    .step(step_v), .restart(v_fall & ~stall),
    .period(cfg.v_period), .width(cfg.v_width),
    .delay(cfg.v_delay), .active(cfg.v_lines),
    .wrap_o(v_wrap), .sync_lo_o(v_lo), .in_win_o(v_win)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_in_q    <= 1'b1;
      v_in_q    <= 1'b1;
      hsync_out <= 1'b1;
      vsync_out <= 1'b1;
      sync_oe   <= 1'b0;
      pix_in_n  <= 1'b1;
    end else begin
      h_in_q    <= hsync_in;
      v_in_q    <= vsync_in;
      hsync_out <= ~(cfg.master & h_lo);
      vsync_out <= ~(cfg.master & v_lo);
      sync_oe   <= cfg.master;
      pix_in_n  <= ~(h_win & v_win & ~stall);
    end
  end

  logic unused_ok;
  assign unused_ok = v_wrap;

  assert_stall_blocks_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    stall |=> pix_in_n);

  assert_slave_sync_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg.master |=> (hsync_out && vsync_out));

  assert_oe_tracks_mode_R11: assert property (@(posedge clk) disable iff (rst)
    cfg.master |=> sync_oe);
endmodule

// File: tb/vsync_timing_gen_tb.sv
module vsync_timing_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic stall = 1'b1;
  logic hsync_in = 1'b1;
  logic vsync_in = 1'b1;
  logic hsync_out, vsync_out, sync_oe, pix_in_n;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  vsync_timing_gen dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stall(stall), .hsync_in(hsync_in),
    .vsync_in(vsync_in), .hsync_out(hsync_out), .vsync_out(vsync_out),
    .sync_oe(sync_oe), .pix_in_n(pix_in_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr16(input int a, input int v);
    wr(a, v & 255);
    wr(a + 1, (v >> 8) & 255);
  endtask

  task automatic do_reset(input bit check_it);
    @(negedge clk);
    rst = 1'b1; stall = 1'b1; hsync_in = 1'b1; vsync_in = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    if (check_it) begin
      chk("R1 hsync_out", int'(hsync_out), 1);
      chk("R1 vsync_out", int'(vsync_out), 1);
      chk("R1 pix_in_n", int'(pix_in_n), 1);
      chk("R1 sync_oe", int'(sync_oe), 0);
    end
  endtask

  task automatic run_master(input int g, input int hp, input int hw, input int hd,
                            input int ha, input int vp, input int vw, input int vd,
                            input int va, input int ncyc, input int smod,
                            input bit junk);
    int mp;
    int hlen, hc, vc, hwe, ap, ehs, evs, epin;
    bit s;
    do_reset(1'b0);
    wr16(0, hp); wr16(2, hw); wr16(4, hd); wr16(6, ha);
    wr16(8, vp); wr16(10, vw); wr16(12, vd); wr16(14, va);
    wr(16, 1 | (g << 1));
    if (junk) begin
      for (int a = 17; a < 32; a++) wr(a, 255);
    end
    mp = 0;
    hlen = g ? 2 * (hp + 1) : hp + 1;
    hwe  = g ? 2 * hw + 1 : hw;
    ap   = g ? ha * 16 : ha * 8;
    for (int i = 0; i < ncyc; i++) begin
      s = (smod != 0) && (i % smod == smod - 1);
      stall = s;
      hc = mp % hlen;
      vc = (mp / hlen) % (vp + 1);
      ehs  = (hc <= hwe) ? 0 : 1;
      evs  = (vc <= vw) ? 0 : 1;
      epin = (!s && hc >= hd && hc < hd + ap && vc >= vd && vc < vd + va) ? 0 : 1;
      @(posedge clk);
      @(negedge clk);
      if (junk) chk("R2 R3 R4 hsync_out", int'(hsync_out), ehs);
      else      chk("R3 R4 hsync_out", int'(hsync_out), ehs);
      chk("R5 vsync_out", int'(vsync_out), evs);
      if (s) chk("R8 pix_in_n during stall", int'(pix_in_n), epin);
      else   chk("R6 R7 pix_in_n", int'(pix_in_n), epin);
      chk("R11 sync_oe", int'(sync_oe), 1);
      if (!s) mp++;
    end
    stall = 1'b1;
  endtask

  task automatic run_slave(input int ncyc);
    int hm, vm, epin;
    bit s, hs_now, vs_now, hs_prev, vs_prev, hf, vf;
    do_reset(1'b0);
    wr16(4, 3); wr16(6, 1); wr16(12, 1); wr16(14, 2);
    wr(16, 0);
    hm = 0; vm = 0; hs_prev = 1'b1; vs_prev = 1'b1;
    for (int i = 0; i < ncyc; i++) begin
      s = (i % 9 == 3);
      hs_now = !((i % 14) == 2 || (i % 14) == 3);
      vs_now = !((i % 70) >= 5 && (i % 70) <= 8);
      stall = s; hsync_in = hs_now; vsync_in = vs_now;
      hf = hs_prev && !hs_now;
      vf = vs_prev && !vs_now;
      epin = (!s && hm >= 3 && hm < 11 && vm >= 1 && vm < 3) ? 0 : 1;
      @(posedge clk);
      @(negedge clk);
      if (s) chk("R10 R8 slave pix_in_n", int'(pix_in_n), epin);
      else   chk("R9 slave pix_in_n", int'(pix_in_n), epin);
      chk("R9 slave hsync_out", int'(hsync_out), 1);
      chk("R9 slave vsync_out", int'(vsync_out), 1);
      chk("R11 slave sync_oe", int'(sync_oe), 0);
      hs_prev = hs_now; vs_prev = vs_now;
      if (!s) begin
        if (hf) hm = 0; else hm++;
        if (vf) vm = 0; else if (hf) vm++;
      end
    end
    stall = 1'b1; hsync_in = 1'b1; vsync_in = 1'b1;
  endtask

  task automatic report;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    #4000000;
    nerr++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    do_reset(1'b1);
    for (int g = 0; g < 2; g++) begin
      for (int ha = 0; ha < 3; ha++) begin
        if (g == 0) run_master(0, 19, 2, 4, ha, 5, 0, 1, 3, 260, (ha == 1) ? 7 : 0, 1'b0);
        else        run_master(1, 9, 1, 2, ha, 5, 1, 2, 2, 260, (ha == 2) ? 5 : 0, 1'b0);
      end
    end
    run_master(0, 299, 257, 256, 2, 1, 0, 0, 2, 700, 11, 1'b1);
    run_slave(320);
    report();
    $finish;
  end
endmodule